// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block generates four pulse-width-modulated outputs. Software programs it through a small memory-mapped register window: a byte address, a write strobe, write data and combinational read data, all in one clock domain. Each channel counts a period of 256 duty steps. Every step lasts a programmable number of input clocks, and the output is high for the first `duty` steps of each period.

Four divider values are stored, one at each divider offset. Each channel chooses one of the four through a 2-bit selector in its duty register, so several channels can share one step length. Per channel, an output enable gates the pin low, a bypass bit holds it high, and a run bit lets the counters advance. A write takes effect on the next cycle. The period in progress is not finished first, and the counters are not restarted.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: Offset 0x00 holds the output enable of channel c at bit c and its bypass at bit 8+c. Offset 0x04 holds the run bit of channel c at bit c. Both read back what was written, and other bits read zero.
- R3: Offset 0x08+4c holds a 16-bit divider in bits [15:0]. Offset 0x18+4c holds the duty count of channel c in bits [7:0] and its divider selector in bits [9:8]. Unused bits read zero.
- R4: A write to any other byte address, including a misaligned one, changes no register, and a read from such an address returns zero.
- R5: With run set, a nonzero selected divider D and duty N, a period lasts 256·D clocks. The output is high for the first N·D clocks of each period, counted from the write that sets run.
- R6: A channel times its steps with the divider whose index is given by its own selector field, not by its channel number.
- R7: A channel whose output enable is clear drives its output low, whatever its other settings.
- R8: A channel with output enable and bypass set drives its output high, regardless of duty, divider and run.
- R9: With a selected divider of zero, a channel that is not bypassed drives low, and its counters hold their value.
- R10: With run clear, a channel's counters are held at zero. When it is enabled and not bypassed, its output is then high exactly when its duty is nonzero.
- R11: A write to a duty, divider or selector field changes the output from the next cycle on. The running counters are neither reset nor allowed to finish the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 4 | PWM outputs, bit c belongs to channel c |

## Verification
Two channels share the step-length question, and they run through one window. One channel points its selector at another channel's divider: a design that indexed dividers by channel number would produce the wrong high time on that channel. A zero divider is selected on purpose, because a design that tested `prescale == divider-1` would wrap through the whole counter range and toggle instead of holding low. A duty change in mid-period must reach the pin on the next cycle, which catches designs that shadow values until the period boundary. A design that lets bypass override a cleared enable shows up as a high pin where low is expected, and one that decodes only some address bits shows up as corrupted registers after the writes to the misaligned and unmapped addresses.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NCH       = 4;
  localparam int SEL_W     = 2;
  localparam int CTRL_OFF  = 'h00;
  localparam int RUN_OFF   = 'h04;
  localparam int DIV_BASE  = 'h08;
  localparam int DUTY_BASE = 'h18;
  localparam int BYP_LSB   = 8;
  localparam int SEL_LSB   = 8;
  localparam int STRIDE    = 4;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic                            wr_en,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data,
  output logic [NCH-1:0]                  oe_q,
  output logic [NCH-1:0]                  byp_q,
  output logic [NCH-1:0]                  run_q,
  output logic [NCH-1:0][DIV_W-1:0]       div_q,
  output logic [NCH-1:0][DUTY_W-1:0]      duty_q,
  output logic [NCH-1:0][SEL_W-1:0]       sel_q
);
  logic [NCH-1:0]             oe_d, byp_d, run_d;
  logic [NCH-1:0][DIV_W-1:0]  div_d;
  logic [NCH-1:0][DUTY_W-1:0] duty_d;
  logic [NCH-1:0][SEL_W-1:0]  sel_d;
  logic                       hit_ctrl, hit_run;
  logic [NCH-1:0]             hit_div, hit_duty;
  logic                       unused_wdata;

  assign unused_wdata = ^wr_data[DATA_W-1:BYP_LSB+NCH];

  always_comb begin
    hit_ctrl = (addr == ADDR_W'(CTRL_OFF));
    hit_run  = (addr == ADDR_W'(RUN_OFF));
    for (int c = 0; c < NCH; c++) begin
      hit_div[c]  = (addr == ADDR_W'(DIV_BASE + STRIDE * c));
      hit_duty[c] = (addr == ADDR_W'(DUTY_BASE + STRIDE * c));
    end
  end

  always_comb begin
    oe_d   = oe_q;
    byp_d  = byp_q;
    run_d  = run_q;
    div_d  = div_q;
    duty_d = duty_q;
    sel_d  = sel_q;
    if (hit_ctrl) begin
      oe_d  = wr_data[NCH-1:0];
      byp_d = wr_data[BYP_LSB +: NCH];
    end
    if (hit_run) run_d = wr_data[NCH-1:0];
    for (int c = 0; c < NCH; c++) begin
      if (hit_div[c]) div_d[c] = wr_data[DIV_W-1:0];
      if (hit_duty[c]) begin
        duty_d[c] = wr_data[DUTY_W-1:0];
        sel_d[c]  = wr_data[SEL_LSB +: SEL_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= '0;
      byp_q  <= '0;
      run_q  <= '0;
      div_q  <= '0;
      duty_q <= '0;
      sel_q  <= '0;
    end else if (wr_en) begin
      oe_q   <= oe_d;
      byp_q  <= byp_d;
      run_q  <= run_d;
      div_q  <= div_d;
      duty_q <= duty_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_ctrl) begin
      rd_data[NCH-1:0]         = oe_q;
      rd_data[BYP_LSB +: NCH]  = byp_q;
    end
    if (hit_run) rd_data[NCH-1:0] = run_q;
    for (int c = 0; c < NCH; c++) begin
      if (hit_div[c]) rd_data[DIV_W-1:0] = div_q[c];
      if (hit_duty[c]) begin
        rd_data[DUTY_W-1:0]         = duty_q[c];
        rd_data[SEL_LSB +: SEL_W]   = sel_q[c];
      end
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              oe,
  input  logic              byp,
  input  logic [DIV_W-1:0]  div,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm,
  output logic [DUTY_W-1:0] step
);
  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [DUTY_W-1:0] step_q, step_d;
  logic              upd;
  logic              div_zero;

  assign div_zero = (div == '0);

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    upd    = 1'b0;
    if (!run) begin
      pre_d  = '0;
      step_d = '0;
      upd    = (pre_q != '0) || (step_q != '0);
    end else if (!div_zero) begin
      upd = 1'b1;
      if (pre_q >= div - 1'b1) begin
        pre_d  = '0;
        step_d = step_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (upd) begin
      pre_q  <= pre_d;
      step_q <= step_d;
    end
  end

  always_comb begin
    if (!oe)           pwm = 1'b0;
    else if (byp)      pwm = 1'b1;
    else if (div_zero) pwm = 1'b0;
    else               pwm = (step_q < duty);
  end

  assign step = step_q;
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0]             oe_q, byp_q, run_q;
  logic [NCH-1:0][DIV_W-1:0]  div_q;
  logic [NCH-1:0][DUTY_W-1:0] duty_q;
  logic [NCH-1:0][SEL_W-1:0]  sel_q;
  logic [NCH-1:0][DIV_W-1:0]  seldiv_w;
  logic [NCH-1:0][DUTY_W-1:0] step_w;

  pwm_quad_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DUTY_W(DUTY_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data),
    .oe_q(oe_q), .byp_q(byp_q), .run_q(run_q),
    .div_q(div_q), .duty_q(duty_q), .sel_q(sel_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign seldiv_w[g] = div_q[sel_q[g]];

    pwm_quad_chan #(
      .DIV_W(DIV_W), .DUTY_W(DUTY_W)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .run(run_q[g]), .oe(oe_q[g]),
      .byp(byp_q[g]), .div(seldiv_w[g]), .duty(duty_q[g]),
      .pwm(pwm_out[g]), .step(step_w[g])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_quad_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wr_en,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NCH-1:0]             oe_q,
  input logic [NCH-1:0]             byp_q,
  input logic [NCH-1:0]             run_q,
  input logic [NCH-1:0]             pwm_out,
  input logic [NCH-1:0][DIV_W-1:0]  seldiv,
  input logic [NCH-1:0][DUTY_W-1:0] step
);
  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(RUN_OFF)) |=> (run_q == $past(wr_data[NCH-1:0]))); // R2

  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q[g] |-> !pwm_out[g]); // R7
    AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q[g] && byp_q[g]) |-> pwm_out[g]); // R8
    AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[g] |=> (step[g] == '0)); // R10
    AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[g] && seldiv[g] == '0) |=> $stable(step[g])); // R9
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step[g] != $past(step[g])) |->
        (step[g] == DUTY_W'($past(step[g]) + 1'b1) || step[g] == '0)); // R5
  end
endmodule

bind pwm_quad pwm_quad_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .oe_q(oe_q), .byp_q(byp_q), .run_q(run_q), .pwm_out(pwm_out),
  .seldiv(seldiv_w), .step(step_w)
);

// File: tb/pwm_quad_test.sv
`timescale 1ns/1ps
module pwm_quad_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // behavioural reference
  bit [3:0] m_oe, m_byp, m_run;
  int m_div[4], m_duty[4], m_sel[4], m_pc[4], m_st[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe = 0; m_byp = 0; m_run = 0;
      for (int c = 0; c < 4; c++) begin
        m_div[c] = 0; m_duty[c] = 0; m_sel[c] = 0; m_pc[c] = 0; m_st[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        int d;
        d = m_div[m_sel[c]];
        if (!m_run[c]) begin
          m_pc[c] = 0; m_st[c] = 0;
        end else if (d != 0) begin
          if (m_pc[c] >= d - 1) begin
            m_pc[c] = 0; m_st[c] = (m_st[c] + 1) % 256;
          end else m_pc[c]++;
        end
      end
      if (wr_en) begin
        if (addr == 8'h00) begin m_oe = wr_data[3:0]; m_byp = wr_data[11:8]; end
        if (addr == 8'h04) m_run = wr_data[3:0];
        for (int c = 0; c < 4; c++) begin
          if (addr == 8'(8 + 4 * c)) m_div[c] = int'(wr_data[15:0]);
          if (addr == 8'(24 + 4 * c)) begin
            m_duty[c] = int'(wr_data[7:0]); m_sel[c] = int'(wr_data[9:8]);
          end
        end
      end
    end
  end

  function automatic bit m_out(int c);
    if (!m_oe[c]) return 0;
    if (m_byp[c]) return 1;
    if (m_div[m_sel[c]] == 0) return 0;
    return m_st[c] < m_duty[c];
  endfunction

  function automatic string m_tag(int c);
    if (!m_oe[c]) return "R7";
    if (m_byp[c]) return "R8";
    if (m_div[m_sel[c]] == 0) return "R9";
    if (!m_run[c]) return "R10";
    return "R5 R11";
  endfunction

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int c = 0; c < 4; c++) begin
        n_run++;
        if (pwm_out[c] !== m_out(c)) begin
          n_fail++;
          $display("FAIL %s ch%0d t=%0t actual=%0b expected=%0b", m_tag(c), c, $time, pwm_out[c], m_out(c));
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(bit [7:0] a, int exp, string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c0, c1, c2, c3;
    rst_n = 1'b0; addr = 0; wr_en = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", int'(pwm_out), 0);
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h04, 0, "R1 run");
    rd(8'h08, 0, "R1 div0");
    rd(8'h18, 0, "R1 duty0");

    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 'h0F0F, "R2 ctrl mask");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 'hF, "R2 run mask");
    wr(8'h04, 0);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 'h3FF, "R3 duty mask");
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, 'hFFFF, "R3 div mask");
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h0A, 32'h0000_1234);
    rd(8'h40, 0, "R4 unmapped");
    rd(8'h0A, 0, "R4 misaligned");
    rd(8'h00, 'h0F0F, "R4 ctrl intact");
    rd(8'h08, 0, "R4 div0 intact");

    wr(8'h00, 0);
    wr(8'h08, 1); wr(8'h0C, 5); wr(8'h10, 3); wr(8'h14, 0);
    wr(8'h18, 'h040); wr(8'h1C, 'h280); wr(8'h20, 'h000); wr(8'h24, 'h380);
    wr(8'h00, 'h040F);
    wr(8'h04, 'hF);
    c0 = 0; c1 = 0; c2 = 0; c3 = 0;
    repeat (768) begin
      @(negedge clk);
      c0 += pwm_out[0]; c1 += pwm_out[1]; c2 += pwm_out[2]; c3 += pwm_out[3];
    end
    chk("R5 ch0 high clocks", c0, 192);
    chk("R6 ch1 high clocks via selector 2", c1, 384);
    chk("R8 ch2 bypass high clocks", c2, 768);
    chk("R9 ch3 zero divider high clocks", c3, 0);

    wr(8'h18, 'h000);
    @(negedge clk);
    chk("R11 duty cleared mid-period", int'(pwm_out[0]), 0);
    wr(8'h18, 'h0FF);
    repeat (40) @(negedge clk);
    wr(8'h08, 0);
    @(negedge clk);
    chk("R11 divider zeroed mid-period", int'(pwm_out[0]), 0);
    wr(8'h08, 2);
    repeat (300) @(negedge clk);

    wr(8'h04, 'hE);
    repeat (5) @(negedge clk);
    chk("R10 halted ch0 with duty", int'(pwm_out[0]), 1);
    wr(8'h18, 'h000);
    @(negedge clk);
    chk("R10 halted ch0 zero duty", int'(pwm_out[0]), 0);

    wr(8'h00, 'h0400);
    @(negedge clk);
    chk("R7 enables clear", int'(pwm_out), 0);
    wr(8'h00, 'h000F);
    repeat (600) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule